// File: doc/BRIEF.md
# Set/Clear Aliased Control Register Bank

This block holds a bank of 32-bit control registers that several bus masters share. Every register can be reached at three addresses. The base window allows ordinary reads and whole-word overwrites. The set window, 0x1000 above the base, ORs the written word into the register. The clear window, 0x2000 above the base, removes every bit that is 1 in the written word. A master can therefore change one bit without a read-modify-write sequence, and two masters that change different bits of the same register never undo each other's work.

Two masters drive a simple memory-mapped slave port each (write strobe, read strobe, byte address, write data). A fixed-priority arbiter accepts one access per cycle and always favours master 0. The accepted access is decoded, applied on the next clock edge, and answered one cycle later on the granted master's acknowledge, error and read-data outputs. The decoded region is 0x10000 bytes and is little-endian. Register offsets step by 4 bytes.

Top module: `setclr_regbank`

## Requirements
- R1: A granted write to base address 0x0000 + 4*i, with i < NUM_REGS, replaces register i with the written word. A granted read of that address returns the current value of register i.
- R2: A granted write to 0x1000 + 4*i sets every bit of register i whose written bit is 1 and leaves the other bits unchanged.
- R3: A granted write to 0x2000 + 4*i clears every bit of register i whose written bit is 1 and leaves the other bits unchanged.
- R4: A read of an address in the set or clear window returns 0 and raises no error when the address is otherwise valid.
- R5: An access raises the error flag, returns 0 and changes no register in any of these cases: address bits [15:12] greater than 2, address bits [1:0] not zero, or word index (address bits [11:2]) not below NUM_REGS.
- R6: An access that asserts both write and read in the same cycle raises the error flag and changes no register.
- R7: A master requests by asserting write or read. Master 0 is granted whenever it requests. Master 1 is granted only in cycles where master 0 does not request. At most one grant is high per cycle, and a master that is not granted holds its request.
- R8: Writes take effect in grant order. A set from one master and a clear from the other, issued in the same cycle to the same register, are both applied, with master 0's write first.
- R9: In the cycle after a grant, the granted master alone sees its acknowledge high, together with its error flag and read data. Read data is 0 for writes and for failed accesses.
- R10: A synchronous active-high reset clears every register to zero and holds both acknowledges low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m0Wr | input | 1 | Master 0 write request |
| m0Rd | input | 1 | Master 0 read request |
| m0Addr | input | ADDR_W | Master 0 byte address |
| m0Wdata | input | DATA_W | Master 0 write data |
| m0Gnt | output | 1 | Master 0 access accepted this cycle |
| m0Ack | output | 1 | Master 0 response valid |
| m0Err | output | 1 | Master 0 access error |
| m0Rdata | output | DATA_W | Master 0 read data |
| m1Wr | input | 1 | Master 1 write request |
| m1Rd | input | 1 | Master 1 read request |
| m1Addr | input | ADDR_W | Master 1 byte address |
| m1Wdata | input | DATA_W | Master 1 write data |
| m1Gnt | output | 1 | Master 1 access accepted this cycle |
| m1Ack | output | 1 | Master 1 response valid |
| m1Err | output | 1 | Master 1 access error |
| m1Rdata | output | DATA_W | Master 1 read data |

## Verification
The bench builds the bank with NUM_REGS = 8 and keeps the other parameters at their defaults. With 8 registers, an aligned address inside a valid window can still lie beyond the last register (word index 8, address 0x020), so the index-range error can be tested next to the last real register at 0x01C. The concurrent-master cases issue a set from master 0 and a clear from master 1 to the same register in the same cycle. They also issue two competing overwrites, which shows from the final register value alone that the writes were applied in grant order.

// File: rtl/setclr_pkg.sv
package setclr_pkg;

  // Write behaviour selected by address bits [13:12] of the accepted access.
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } wr_op_e;

  // Strobes passed from control to datapath for one accepted access.
  typedef struct packed {
    logic   access;   // an access was granted this cycle
    logic   wrEn;     // legal write: update the addressed register
    logic   rdEn;     // legal read of the base window: return register value
    logic   errHit;   // access rejected
    wr_op_e op;       // write behaviour
    logic   srcId;    // granted master
  } strobe_t;

  localparam int WIN_LSB = 12;

endpackage

// File: rtl/setclr_arbiter.sv
module setclr_arbiter #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              m0Wr,
  input  logic              m0Rd,
  input  logic [ADDR_W-1:0] m0Addr,
  input  logic [DATA_W-1:0] m0Wdata,
  input  logic              m1Wr,
  input  logic              m1Rd,
  input  logic [ADDR_W-1:0] m1Addr,
  input  logic [DATA_W-1:0] m1Wdata,
  output logic              m0Gnt,
  output logic              m1Gnt,
  output logic              selValid,
  output logic              selWr,
  output logic              selRd,
  output logic [ADDR_W-1:0] selAddr,
  output logic [DATA_W-1:0] selWdata,
  output logic              selId
);

  logic m0Req;
  logic m1Req;

  assign m0Req = m0Wr | m0Rd;
  assign m1Req = m1Wr | m1Rd;

  // Fixed priority: master 0 always wins.
  assign m0Gnt = m0Req;
  assign m1Gnt = m1Req & ~m0Req;

  always_comb begin
    selValid = m0Req | m1Req;
    selId    = ~m0Req;
    if (m0Req) begin
      selWr    = m0Wr;
      selRd    = m0Rd;
      selAddr  = m0Addr;
      selWdata = m0Wdata;
    end else begin
      selWr    = m1Wr;
      selRd    = m1Rd;
      selAddr  = m1Addr;
      selWdata = m1Wdata;
    end
  end

endmodule

// File: rtl/setclr_ctrl.sv
module setclr_ctrl
  import setclr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4
) (
  input  logic              selValid,
  input  logic              selWr,
  input  logic              selRd,
  input  logic [ADDR_W-1:0] selAddr,
  input  logic              selId,
  output strobe_t           strb,
  output logic [IDX_W-1:0]  idx
);

  localparam int WF_W = ADDR_W - WIN_LSB;
  localparam int WO_W = WIN_LSB - 2;
  localparam logic [WF_W-1:0] WIN_LAST = WF_W'(2);
  localparam logic [WO_W-1:0] REG_LIMIT = WO_W'(NUM_REGS);

  logic [WF_W-1:0] winField;
  logic [WO_W-1:0] wordOff;
  logic            misaligned;
  logic            winBad;
  logic            idxBad;
  logic            conflict;
  logic            reject;
  wr_op_e          op;

  assign winField   = selAddr[ADDR_W-1:WIN_LSB];
  assign wordOff    = selAddr[WIN_LSB-1:2];
  assign misaligned = |selAddr[1:0];
  assign winBad     = winField > WIN_LAST;
  assign idxBad     = wordOff >= REG_LIMIT;
  assign conflict   = selWr & selRd;
  assign reject     = misaligned | winBad | idxBad | conflict;

  always_comb begin
    unique case (winField[1:0])
      2'd0:    op = OP_WRITE;
      2'd1:    op = OP_SET;
      2'd2:    op = OP_CLEAR;
      default: op = OP_NONE;
    endcase
  end

  always_comb begin
    strb.access = selValid;
    strb.errHit = selValid & reject;
    strb.wrEn   = selValid & selWr & ~reject;
    strb.rdEn   = selValid & selRd & ~reject & (op == OP_WRITE);
    strb.op     = op;
    strb.srcId  = selId;
  end

  assign idx = wordOff[IDX_W-1:0];

endmodule

// File: rtl/setclr_datapath.sv
module setclr_datapath
  import setclr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              respAck,
  output logic              respErr,
  output logic              respId,
  output logic [DATA_W-1:0] respData
);

  logic [DATA_W-1:0] regArr [NUM_REGS];
  logic [DATA_W-1:0] rdMux;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              hit;
    logic [DATA_W-1:0] q;

    assign hit = strb.wrEn && (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (hit) begin
        case (strb.op)
          OP_WRITE: q <= wdata;
          OP_SET:   q <= q | wdata;
          OP_CLEAR: q <= q & ~wdata;
          default:  q <= q;
        endcase
      end
    end

    assign regArr[g] = q;
  end

  assign rdMux = regArr[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      respAck  <= 1'b0;
      respErr  <= 1'b0;
      respId   <= 1'b0;
      respData <= '0;
    end else begin
      respAck  <= strb.access;
      respErr  <= strb.errHit;
      respId   <= strb.srcId;
      respData <= strb.rdEn ? rdMux : '0;
    end
  end

endmodule

// File: rtl/setclr_regbank.sv
module setclr_regbank
  import setclr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m0Wr,
  input  logic              m0Rd,
  input  logic [ADDR_W-1:0] m0Addr,
  input  logic [DATA_W-1:0] m0Wdata,
  output logic              m0Gnt,
  output logic              m0Ack,
  output logic              m0Err,
  output logic [DATA_W-1:0] m0Rdata,
  input  logic              m1Wr,
  input  logic              m1Rd,
  input  logic [ADDR_W-1:0] m1Addr,
  input  logic [DATA_W-1:0] m1Wdata,
  output logic              m1Gnt,
  output logic              m1Ack,
  output logic              m1Err,
  output logic [DATA_W-1:0] m1Rdata
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic              selValid;
  logic              selWr;
  logic              selRd;
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selWdata;
  logic              selId;
  strobe_t           strb;
  logic [IDX_W-1:0]  idx;
  logic              respAck;
  logic              respErr;
  logic              respId;
  logic [DATA_W-1:0] respData;

  setclr_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .m0Wr(m0Wr), .m0Rd(m0Rd), .m0Addr(m0Addr), .m0Wdata(m0Wdata),
    .m1Wr(m1Wr), .m1Rd(m1Rd), .m1Addr(m1Addr), .m1Wdata(m1Wdata),
    .m0Gnt(m0Gnt), .m1Gnt(m1Gnt),
    .selValid(selValid), .selWr(selWr), .selRd(selRd),
    .selAddr(selAddr), .selWdata(selWdata), .selId(selId)
  );

  setclr_ctrl #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_ctrl (
    .selValid(selValid), .selWr(selWr), .selRd(selRd),
    .selAddr(selAddr), .selId(selId), .strb(strb), .idx(idx)
  );

  setclr_datapath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .idx(idx), .wdata(selWdata),
    .respAck(respAck), .respErr(respErr), .respId(respId), .respData(respData)
  );

  assign m0Ack   = respAck & ~respId;
  assign m1Ack   = respAck &  respId;
  assign m0Err   = m0Ack & respErr;
  assign m1Err   = m1Ack & respErr;
  assign m0Rdata = respId ? '0 : respData;
  assign m1Rdata = respId ? respData : '0;

endmodule

// File: rtl/setclr_regbank_chk.sv
module setclr_regbank_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              m0Wr,
  input logic              m0Rd,
  input logic [ADDR_W-1:0] m0Addr,
  input logic              m0Gnt,
  input logic              m0Ack,
  input logic              m0Err,
  input logic [DATA_W-1:0] m0Rdata,
  input logic              m1Wr,
  input logic              m1Rd,
  input logic              m1Gnt,
  input logic              m1Ack
);

  localparam int WF_W = ADDR_W - 12;
  localparam logic [WF_W-1:0] WIN_SETW = WF_W'(1);
  localparam logic [WF_W-1:0] WIN_CLRW = WF_W'(2);

  logic [WF_W-1:0] winField;
  assign winField = m0Addr[ADDR_W-1:12];

  p_gnt_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(m0Gnt && m1Gnt));

  p_prio_r7: assert property (@(posedge clk) disable iff (rst)
    (m0Wr || m0Rd) |-> (m0Gnt && !m1Gnt));

  p_m1_served_r7: assert property (@(posedge clk) disable iff (rst)
    ((m1Wr || m1Rd) && !(m0Wr || m0Rd)) |-> m1Gnt);

  p_ack0_r9: assert property (@(posedge clk) disable iff (rst)
    m0Gnt |=> (m0Ack && !m1Ack));

  p_ack1_r9: assert property (@(posedge clk) disable iff (rst)
    m1Gnt |=> (m1Ack && !m0Ack));

  p_noack_r9: assert property (@(posedge clk) disable iff (rst)
    (!m0Gnt && !m1Gnt) |=> (!m0Ack && !m1Ack));

  p_alias_rd_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (m0Gnt && m0Rd && !m0Wr && (winField == WIN_SETW || winField == WIN_CLRW))
      |=> (m0Rdata == '0));

  p_bad_window_r5: assert property (@(posedge clk) disable iff (rst)
    (m0Gnt && winField > WIN_CLRW) |=> (m0Err && m0Rdata == '0));

  p_conflict_r6: assert property (@(posedge clk) disable iff (rst)
    (m0Gnt && m0Wr && m0Rd) |=> m0Err);

  p_write_nodata_r9: assert property (@(posedge clk) disable iff (rst)
    (m0Gnt && m0Wr) |=> (m0Rdata == '0));

endmodule

bind setclr_regbank setclr_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .m0Wr(m0Wr), .m0Rd(m0Rd), .m0Addr(m0Addr), .m0Gnt(m0Gnt),
  .m0Ack(m0Ack), .m0Err(m0Err), .m0Rdata(m0Rdata),
  .m1Wr(m1Wr), .m1Rd(m1Rd), .m1Gnt(m1Gnt), .m1Ack(m1Ack)
);

// File: tb/tb_setclr_regbank.sv
module tb_setclr_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 8;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m0Wr = 0, m0Rd = 0, m1Wr = 0, m1Rd = 0;
  logic [AW-1:0] m0Addr = '0, m1Addr = '0;
  logic [DW-1:0] m0Wdata = '0, m1Wdata = '0;
  logic m0Gnt, m0Ack, m0Err, m1Gnt, m1Ack, m1Err;
  logic [DW-1:0] m0Rdata, m1Rdata;

  int nRun = 0;
  int nFail = 0;

  setclr_regbank #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NREGS)) dut (
    .clk(clk), .rst(rst),
    .m0Wr(m0Wr), .m0Rd(m0Rd), .m0Addr(m0Addr), .m0Wdata(m0Wdata),
    .m0Gnt(m0Gnt), .m0Ack(m0Ack), .m0Err(m0Err), .m0Rdata(m0Rdata),
    .m1Wr(m1Wr), .m1Rd(m1Rd), .m1Addr(m1Addr), .m1Wdata(m1Wdata),
    .m1Gnt(m1Gnt), .m1Ack(m1Ack), .m1Err(m1Err), .m1Rdata(m1Rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic          mst;
    logic          wr;
    logic          rd;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          expErr;
    logic [DW-1:0] expData;
    logic [3:0]    req;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b1, 1'b0, 16'h0004, 32'hA5A5_0F0F, 1'b0, 32'h0,         4'd1}, // R1 overwrite
    '{1'b0, 1'b0, 1'b1, 16'h0004, 32'h0,         1'b0, 32'hA5A5_0F0F, 4'd1},
    '{1'b1, 1'b1, 1'b0, 16'h1004, 32'h0000_F0F0, 1'b0, 32'h0,         4'd2}, // R2 set
    '{1'b1, 1'b0, 1'b1, 16'h0004, 32'h0,         1'b0, 32'hA5A5_FFFF, 4'd2},
    '{1'b0, 1'b1, 1'b0, 16'h2004, 32'hA000_00FF, 1'b0, 32'h0,         4'd3}, // R3 clear
    '{1'b0, 1'b0, 1'b1, 16'h0004, 32'h0,         1'b0, 32'h05A5_FF00, 4'd3},
    '{1'b0, 1'b0, 1'b1, 16'h1004, 32'h0,         1'b0, 32'h0,         4'd4}, // R4 alias reads
    '{1'b1, 1'b0, 1'b1, 16'h2004, 32'h0,         1'b0, 32'h0,         4'd4},
    '{1'b0, 1'b1, 1'b0, 16'h3004, 32'hFFFF_FFFF, 1'b1, 32'h0,         4'd5}, // R5 bad window
    '{1'b0, 1'b1, 1'b0, 16'h1006, 32'hFFFF_FFFF, 1'b1, 32'h0,         4'd5}, // R5 unaligned
    '{1'b1, 1'b1, 1'b0, 16'h0020, 32'hFFFF_FFFF, 1'b1, 32'h0,         4'd5}, // R5 index 8
    '{1'b0, 1'b1, 1'b0, 16'h2020, 32'hFFFF_FFFF, 1'b1, 32'h0,         4'd5},
    '{1'b0, 1'b0, 1'b1, 16'h0004, 32'h0,         1'b0, 32'h05A5_FF00, 4'd5}, // R5 unchanged
    '{1'b0, 1'b0, 1'b1, 16'hF000, 32'h0,         1'b1, 32'h0,         4'd5},
    '{1'b0, 1'b0, 1'b1, 16'h001C, 32'h0,         1'b0, 32'h0,         4'd1}, // R1 last reg
    '{1'b0, 1'b1, 1'b0, 16'h001C, 32'hDEAD_BEEF, 1'b0, 32'h0,         4'd1},
    '{1'b0, 1'b0, 1'b1, 16'h001C, 32'h0,         1'b0, 32'hDEAD_BEEF, 4'd1},
    '{1'b0, 1'b1, 1'b0, 16'h101C, 32'h0,         1'b0, 32'h0,         4'd2}, // R2 zero set
    '{1'b0, 1'b0, 1'b1, 16'h001C, 32'h0,         1'b0, 32'hDEAD_BEEF, 4'd2},
    '{1'b1, 1'b1, 1'b0, 16'h1008, 32'hFFFF_FFFF, 1'b0, 32'h0,         4'd2},
    '{1'b1, 1'b0, 1'b1, 16'h0008, 32'h0,         1'b0, 32'hFFFF_FFFF, 4'd2}
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearInputs();
    m0Wr = 0; m0Rd = 0; m0Addr = '0; m0Wdata = '0;
    m1Wr = 0; m1Rd = 0; m1Addr = '0; m1Wdata = '0;
  endtask

  // One access from one master; samples the response one cycle after grant.
  task automatic access(input logic mst, input logic wr, input logic rd,
                        input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic ack, output logic err, output logic [DW-1:0] q);
    @(negedge clk);
    if (!mst) begin m0Wr = wr; m0Rd = rd; m0Addr = a; m0Wdata = d; end
    else      begin m1Wr = wr; m1Rd = rd; m1Addr = a; m1Wdata = d; end
    @(posedge clk); #1;
    if (!mst) begin ack = m0Ack; err = m0Err; q = m0Rdata; end
    else      begin ack = m1Ack; err = m1Err; q = m1Rdata; end
    clearInputs();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic ack, err;
    logic [DW-1:0] q;

    // R10 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R10 ack0 during reset", {31'b0, m0Ack}, 32'h0);
    check("R10 ack1 during reset", {31'b0, m1Ack}, 32'h0);
    @(negedge clk) rst = 1'b0;
    access(1'b0, 1'b0, 1'b1, 16'h0000, 32'h0, ack, err, q);
    check("R10 reg0 after reset", q, 32'h0);
    check("R9 read ack", {31'b0, ack}, 32'h1);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i].mst, VEC[i].wr, VEC[i].rd, VEC[i].addr, VEC[i].wdata, ack, err, q);
      check($sformatf("R%0d vec%0d ack", VEC[i].req, i), {31'b0, ack}, 32'h1);
      check($sformatf("R%0d vec%0d err", VEC[i].req, i), {31'b0, err}, {31'b0, VEC[i].expErr});
      check($sformatf("R%0d vec%0d data", VEC[i].req, i), q, VEC[i].expData);
    end

    // R6 write and read together
    access(1'b0, 1'b1, 1'b1, 16'h0004, 32'h1234_5678, ack, err, q);
    check("R6 conflict err", {31'b0, err}, 32'h1);
    access(1'b0, 1'b0, 1'b1, 16'h0004, 32'h0, ack, err, q);
    check("R6 reg unchanged", q, 32'h05A5_FF00);

    // R7/R8 concurrent set (m0) and clear (m1) on register 3
    access(1'b0, 1'b1, 1'b0, 16'h000C, 32'h0000_0033, ack, err, q);
    @(negedge clk);
    m0Wr = 1; m0Addr = 16'h100C; m0Wdata = 32'h0000_00F0;
    m1Wr = 1; m1Addr = 16'h200C; m1Wdata = 32'h0000_0030;
    #1;
    check("R7 m0 granted", {31'b0, m0Gnt}, 32'h1);
    check("R7 m1 waits", {31'b0, m1Gnt}, 32'h0);
    @(posedge clk); #1;
    m0Wr = 0; m0Addr = '0; m0Wdata = '0;
    #1;
    check("R9 m0 ack first", {31'b0, m0Ack}, 32'h1);
    check("R9 m1 no ack yet", {31'b0, m1Ack}, 32'h0);
    check("R7 m1 granted when m0 idle", {31'b0, m1Gnt}, 32'h1);
    @(posedge clk); #1;
    check("R9 m1 ack", {31'b0, m1Ack}, 32'h1);
    check("R9 m0 no ack", {31'b0, m0Ack}, 32'h0);
    clearInputs();
    access(1'b1, 1'b0, 1'b1, 16'h000C, 32'h0, ack, err, q);
    check("R8 set and clear both applied", q, 32'h0000_00C3);

    // R8 competing overwrites: m1 granted last wins
    @(negedge clk);
    m0Wr = 1; m0Addr = 16'h0010; m0Wdata = 32'h0000_0111;
    m1Wr = 1; m1Addr = 16'h0010; m1Wdata = 32'h0000_0222;
    @(posedge clk); #1;
    m0Wr = 0; m0Addr = '0; m0Wdata = '0;
    @(posedge clk); #1;
    clearInputs();
    access(1'b0, 1'b0, 1'b1, 16'h0010, 32'h0, ack, err, q);
    check("R8 grant order overwrite", q, 32'h0000_0222);

    // R10 reset mid-run clears registers
    @(negedge clk) rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R10 ack held low", {31'b0, m0Ack}, 32'h0);
    @(negedge clk) rst = 1'b0;
    access(1'b0, 1'b0, 1'b1, 16'h0004, 32'h0, ack, err, q);
    check("R10 reg1 cleared", q, 32'h0);
    access(1'b1, 1'b0, 1'b1, 16'h001C, 32'h0, ack, err, q);
    check("R10 reg7 cleared", q, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule